// File: doc/BRIEF.md
# Two-Channel PWM Generator with Sawtooth and Triangle Counting

This block makes two pulse-width-modulated outputs from one shared time base. A prescaler divides the clock into counting ticks. A single counter then steps on those ticks in one of two shapes. In sawtooth mode the counter only rises and then restarts, so both channels turn on at the same instant. In triangle mode the counter rises and then falls, so each channel's pulse is centred on the turning point of the count. Each channel has its own compare threshold and its own polarity bit. Because the two channels share one counter, software can choose whether their pulses coincide, nest inside each other or never overlap. This is useful when one supply must be shared between two loads.

The configuration inputs act as the shadow copy of the settings. The block copies them into its working registers only at the end of a counting period, so a change never cuts a pulse short. A one-clock strobe marks each period boundary.

Top module: `dual_pwm_timer`

## Requirements
- R1: In sawtooth mode (`cfg_center`=0) the count runs 0,1,…,P-1 and then returns to 0, where P is the active period (a P of 0 acts as 1). A channel is active while count < compare. One period lasts P·(D+1) clocks, where D is the active prescale value, and the active time is min(C,P)·(D+1) clocks, where C is the channel's compare value.
- R2: In triangle mode (`cfg_center`=1) the count runs 0,1,…,P-1, then P-1,…,1,0, so each value occurs twice. One period lasts 2·P·(D+1) clocks. A channel is active while count ≥ P−C with C≠0, which gives 2·min(C,P)·(D+1) active clocks centred on the peak of the count.
- R3: The count advances once every D+1 clocks. Triangle mode with prescale D gives the same period as sawtooth mode with prescale 2D+1 and the same P.
- R4: Polarity bit 0 means the channel is active-high, so the output is 1 while the channel is active. Polarity bit 1 means active-low, so the output is 0 while active and 1 otherwise. Bit 0 of `cfg_pol` and row 0 of `cfg_cmp` belong to `pwm_out[0]`; bit 1 and row 1 belong to `pwm_out[1]`.
- R5: A compare value of 0 holds the output constantly at its inactive level. A compare value ≥ P holds it constantly at its active level. An active-low channel with compare 0 stays at 1 from the first clock after reset onward.
- R6: Changes to the period, prescale, mode, compare or polarity inputs take effect only at the next period boundary. A period already in progress keeps its old length and levels.
- R7: A synchronous active-high reset clears the count and the prescaler, loads the working registers from the configuration inputs, and drives each output to its inactive level, which equals its polarity bit.
- R8: `upd_pulse` is high for one clock at each period boundary, in the first clock of the new period (count 0).
- R9: In triangle mode, two active-high channels with different compare values give nested pulses: whenever the shorter pulse is high, the longer one is also high.
- R10: In triangle mode, with one channel active-high at compare 0.3·P and the other active-low at compare 0.7·P, the two high intervals never overlap and gaps where both outputs are low separate them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_psc | input | PSC_W | Prescale value D; the count advances every D+1 clocks |
| cfg_period | input | CNT_W | Period P in count steps |
| cfg_center | input | 1 | 0 = sawtooth counting, 1 = triangle counting |
| cfg_cmp | input | 2 x CNT_W | Compare value per channel, row i for channel i |
| cfg_pol | input | 2 | Polarity per channel, 1 = active-low |
| pwm_out | output | 2 | Registered PWM outputs |
| upd_pulse | output | 1 | One-clock strobe at each period boundary |

## Verification
The bench measures the high time and the repeat period of both channels in all four combinations of counting shape and polarity. A design that counts the triangle peak only once, or that compares on the wrong side of the count, gives high times that are off by a step, or pulses centred on the valley. Constant levels are checked at compare 0 and at compare above P, and for an active-low channel held at 0% from reset. A design that mishandles these cases would glitch for one step or start at the wrong level. Changing the period in the middle of a period must leave that period's length unchanged, and the bench checks that triangle mode with prescale D matches the period of sawtooth mode with prescale 2D+1. The nesting and separation checks catch a design whose channels drift relative to each other or overlap at the pulse edges.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int NCH = 2;

  typedef enum logic {
    SHAPE_SAW = 1'b0,
    SHAPE_TRI = 1'b1
  } cnt_shape_e;
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] pc;

  assign tick = (pc >= div);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + 1'b1;
  end
endmodule

// File: rtl/pwm2_counter.sv
module pwm2_counter
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_shape_e       shape,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic going_down;
  logic at_top;

  // last value before the top of the ramp
  assign at_top = ({1'b0, cnt} + 1'b1) >= {1'b0, period};

  always_comb begin
    if (shape == SHAPE_SAW) wrap = tick && at_top;
    else                    wrap = tick && going_down && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      cnt        <= '0;
      going_down <= 1'b0;
    end else if (tick) begin
      if (shape == SHAPE_SAW) begin
        cnt <= cnt + 1'b1;
      end else if (!going_down) begin
        if (at_top) going_down <= 1'b1;   // repeat the peak value once
        else        cnt <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm2_compare.sv
module pwm2_compare
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_shape_e       shape,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp,
  input  logic             pol_low,
  input  logic             rst_level,
  output logic             out
);
  logic active;
  logic [CNT_W:0] sum_cc;

  assign sum_cc = {1'b0, cnt} + {1'b0, cmp};

  always_comb begin
    if (shape == SHAPE_SAW) active = (cnt < cmp);
    else                    active = (cmp != '0) && (sum_cc >= {1'b0, period});
  end

  always_ff @(posedge clk) begin
    if (rst) out <= rst_level;
    else     out <= active ^ pol_low;
  end
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PSC_W-1:0]          cfg_psc,
  input  logic [CNT_W-1:0]          cfg_period,
  input  logic                      cfg_center,
  input  logic [NCH-1:0][CNT_W-1:0] cfg_cmp,
  input  logic [NCH-1:0]            cfg_pol,
  output logic [NCH-1:0]            pwm_out,
  output logic                      upd_pulse
);
  logic [PSC_W-1:0]          psc_r;
  logic [CNT_W-1:0]          per_r;
  cnt_shape_e                shape_r;
  logic [NCH-1:0][CNT_W-1:0] cmp_r;
  logic [NCH-1:0]            pol_r;

  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;

  // working copies follow the inputs only at a period boundary
  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      psc_r   <= cfg_psc;
      per_r   <= cfg_period;
      shape_r <= cnt_shape_e'(cfg_center);
      cmp_r   <= cfg_cmp;
      pol_r   <= cfg_pol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) upd_pulse <= 1'b0;
    else     upd_pulse <= wrap;
  end

  pwm2_prescaler #(.PSC_W(PSC_W)) psc_i (
    .clk  (clk),
    .rst  (rst),
    .div  (psc_r),
    .tick (tick)
  );

  pwm2_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .shape  (shape_r),
    .period (per_r),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm2_compare #(.CNT_W(CNT_W)) cmp_i (
      .clk       (clk),
      .rst       (rst),
      .shape     (shape_r),
      .cnt       (cnt),
      .period    (per_r),
      .cmp       (cmp_r[g]),
      .pol_low   (pol_r[g]),
      .rst_level (cfg_pol[g]),
      .out       (pwm_out[g])
    );
  end
endmodule

// File: rtl/dual_pwm_timer_chk.sv
module dual_pwm_timer_chk
  import pwm2_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            cfg_pol,
  input logic [NCH-1:0]            pwm_out,
  input logic                      upd_pulse,
  input logic                      tick,
  input logic [CNT_W-1:0]          cnt,
  input logic [CNT_W-1:0]          per_r,
  input logic [NCH-1:0][CNT_W-1:0] cmp_r,
  input logic [NCH-1:0]            pol_r
);
  // R8: boundary strobe lines up with a fresh count
  assert_upd_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> (cnt == '0));

  // R1: the count never passes the active period
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    (per_r == '0) ? (cnt == '0) : (cnt < per_r));

  // R3: outputs move only after a prescaler tick
  assert_out_steps_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(tick, 2)) |-> $stable(pwm_out));

  for (genvar g = 0; g < NCH; g++) begin : g_c
    // R7: out of reset each output sits at its inactive level
    assert_reset_level_R7: assert property (@(posedge clk)
      $past(rst) |-> (pwm_out[g] == $past(cfg_pol[g])));

    // R5: compare zero means a constant inactive level
    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (rst)
      $past(!rst && (cmp_r[g] == '0)) |-> (pwm_out[g] == $past(pol_r[g])));
  end
endmodule

bind dual_pwm_timer dual_pwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cfg_pol   (cfg_pol),
  .pwm_out   (pwm_out),
  .upd_pulse (upd_pulse),
  .tick      (tick),
  .cnt       (cnt),
  .per_r     (per_r),
  .cmp_r     (cmp_r),
  .pol_r     (pol_r)
);

// File: tb/dual_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module dual_pwm_timer_tb_top;
  localparam int CW = 16;
  localparam int PW = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PW-1:0]     cfg_psc = '0;
  logic [CW-1:0]     cfg_period = 16'd4;
  logic              cfg_center = 1'b0;
  logic [1:0][CW-1:0] cfg_cmp;
  logic [1:0]        cfg_pol = 2'b10;
  logic [1:0]        pwm_out;
  logic              upd_pulse;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit arm = 0;

  int    hi_q  [2][$];
  int    per_q [2][$];
  string tag_q [2][$];

  always #2.5 clk = ~clk;

  dual_pwm_timer #(.CNT_W(CW), .PSC_W(PW)) dut_i (
    .clk(clk), .rst(rst), .cfg_psc(cfg_psc), .cfg_period(cfg_period),
    .cfg_center(cfg_center), .cfg_cmp(cfg_cmp), .cfg_pol(cfg_pol),
    .pwm_out(pwm_out), .upd_pulse(upd_pulse)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measures each channel and compares with queued expectations
  int  t = 0;
  int  rise_t [2];
  int  fall_t [2];
  bit  seen   [2];
  bit  prev   [2];
  always @(negedge clk) begin
    t++;
    for (int c = 0; c < 2; c++) begin
      if (!arm) begin
        seen[c] = 0;
      end else begin
        if (pwm_out[c] && !prev[c]) begin
          if (seen[c] && hi_q[c].size() > 0) begin
            int eh, ep;
            string tg;
            eh = hi_q[c].pop_front();
            ep = per_q[c].pop_front();
            tg = tag_q[c].pop_front();
            check($sformatf("%s ch%0d period", tg, c), t - rise_t[c], ep);
            check($sformatf("%s ch%0d high", tg, c), fall_t[c] - rise_t[c], eh);
          end
          rise_t[c] = t;
          seen[c] = 1;
        end
        if (!pwm_out[c] && prev[c]) fall_t[c] = t;
      end
      prev[c] = pwm_out[c];
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_upd();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!upd_pulse && g < 5000);
  endtask

  task automatic setcfg(input bit ctr, input int psc, input int per,
                        input int ca, input int cb, input bit pa, input bit pb);
    @(posedge clk); #1;
    cfg_center = ctr; cfg_psc = PW'(psc); cfg_period = CW'(per);
    cfg_cmp[0] = CW'(ca); cfg_cmp[1] = CW'(cb); cfg_pol = {pb, pa};
    wait_upd();
    wait_upd();
  endtask

  task automatic measure(input string tag, input int ha, input int hb, input int per);
    int g = 0;
    for (int k = 0; k < 2; k++) begin
      hi_q[0].push_back(ha); per_q[0].push_back(per); tag_q[0].push_back(tag);
      hi_q[1].push_back(hb); per_q[1].push_back(per); tag_q[1].push_back(tag);
    end
    @(posedge clk); #1; arm = 1;
    while ((hi_q[0].size() > 0 || hi_q[1].size() > 0) && g < 4000) begin
      @(negedge clk); g++;
    end
    check({tag, " all measurements taken"}, hi_q[0].size() + hi_q[1].size(), 0);
    hi_q[0].delete(); per_q[0].delete(); tag_q[0].delete();
    hi_q[1].delete(); per_q[1].delete(); tag_q[1].delete();
    @(posedge clk); #1; arm = 0;
  endtask

  task automatic upd_gap(output int n);
    wait_upd();
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!upd_pulse && n < 5000);
  endtask

  initial begin
    int n, bad, both, gap, lows;
    cfg_cmp[0] = 16'd2;
    cfg_cmp[1] = 16'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: outputs at inactive level (= polarity bit) during reset
    check("R7 reset ch0 level", int'(pwm_out[0]), 0);
    check("R7 reset ch1 level", int'(pwm_out[1]), 1);
    check("R8 strobe low in reset", int'(upd_pulse), 0);
    @(posedge clk); #1; rst = 0;
    // R5/R4: active-low channel at 0% stays high straight after reset
    lows = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!pwm_out[1]) lows++;
    end
    check("R5 active-low zero duty low clocks", lows, 0);

    // R1 sawtooth, both active-high, 50%: P=10, D=1
    setcfg(0, 1, 10, 5, 5, 0, 0);
    measure("R1 saw same pol", 10, 10, 20);
    // R4 sawtooth mixed polarity, compare 3: active-low high time (10-3)*2
    setcfg(0, 1, 10, 3, 3, 0, 1);
    measure("R4 saw mixed pol", 6, 14, 20);
    // R8: strobe spacing equals the sawtooth period
    upd_gap(n);
    check("R8 saw strobe spacing", n, 20);

    // R2 triangle, both active-high, compares 7 and 3
    setcfg(1, 0, 10, 7, 3, 0, 0);
    measure("R2 tri same pol", 14, 6, 20);
    // R9: shorter pulse always inside longer one
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pwm_out[1] && !pwm_out[0]) bad++;
    end
    check("R9 nested violations", bad, 0);

    // R10: triangle, ch0 active-high cmp 3, ch1 active-low cmp 7
    setcfg(1, 0, 10, 3, 7, 0, 1);
    measure("R10 tri mixed pol", 6, 6, 20);
    both = 0; gap = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pwm_out[0] && pwm_out[1]) both++;
      if (!pwm_out[0] && !pwm_out[1]) gap++;
    end
    check("R10 overlap clocks", both, 0);
    check("R10 gap present", int'(gap > 0), 1);

    // R3: triangle at D=1 matches sawtooth at D=3
    setcfg(0, 3, 10, 5, 5, 0, 0);
    upd_gap(n);
    check("R3 saw D=3 period", n, 40);
    setcfg(1, 1, 10, 5, 5, 0, 0);
    upd_gap(n);
    check("R3 tri D=1 period", n, 40);

    // R5: compare above P is constant active, compare 0 constant inactive
    setcfg(0, 0, 8, 9, 0, 0, 0);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!pwm_out[0] || pwm_out[1]) bad++;
    end
    check("R5 constant levels deviations", bad, 0);

    // R6: a period change mid-period applies only from the next boundary
    setcfg(0, 0, 10, 5, 5, 0, 0);
    wait_upd();
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    cfg_period = 16'd6;
    while (!upd_pulse && n < 5000) begin @(negedge clk); n++; end
    check("R6 current period kept", n, 10);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_pulse && n < 5000);
    check("R6 new period applied", n, 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule